// File: doc/BRIEF.md
# Sorted Delay-Line Tap Encoder

This block converts the captured state of a carry-chain delay line into a fine-time code. Each clock cycle it receives the registered tap bits of the chain. The chain has four taps per carry element, and the signal enters at the low end. Neighbouring taps inside one carry element do not always switch in delay order. A fixed lane order therefore rearranges the four taps of every carry element, so that the vector is sorted by true delay. Once the taps are sorted, an edge in flight shows up as one unbroken run starting at position 0. The widths of the delay bins can still differ.

The encoder counts how many sorted bits, starting at position 0, share the value of position 0. That count is the address into a downstream bin-width lookup table. The value of position 0 gives the polarity of the edge. A vector whose bits are all equal means no edge was inside the line, and no result is produced. The count is computed in two register stages so that long chains still meet timing. Stage one scans fixed-size groups of taps. Stage two merges the group results.

Top module: `tap_encoder`

## Requirements
- R1: The block has 4*NUM_CARRY tap inputs. Sorted bit 4c+j is taken from raw bit 4c+LANE_ORDER[j] for every carry element c. The default LANE_ORDER is (0,2,1,3), which exchanges lanes 1 and 2 inside each group of four.
- R2: When a result is valid, out_count equals the number of consecutive sorted bits, starting at sorted bit 0, whose value equals sorted bit 0.
- R3: When a result is valid, out_rising equals sorted bit 0: 1 for a leading run of ones (rising edge), 0 for a leading run of zeros (falling edge).
- R4: When all tap bits are equal (all zeros or all ones), out_valid is 0. Whenever out_valid is 0, out_count and out_rising are 0.
- R5: A result appears on the outputs exactly two clock edges after the tap vector is sampled. A new vector is accepted on every cycle.
- R6: A synchronous active-high reset clears out_valid, out_rising and out_count at the next clock edge.
- R7: A valid out_count lies between 1 and 4*NUM_CARRY-1. Sorted bits after the first bit that differs from sorted bit 0 have no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| tap_raw | input | 4*NUM_CARRY | Registered raw delay-line taps, in chain order |
| out_valid | output | 1 | A result is present this cycle |
| out_rising | output | 1 | Polarity of the captured edge (1 = rising) |
| out_count | output | $clog2(4*NUM_CARRY) | Length of the leading identical run in the sorted vector |

## Verification
The assertions assume that tap_raw is a clean registered vector that changes only at clock edges. They also assume that any single capture holds at most one edge: after sorting, the vector has one leading run and an arbitrary tail. The tail matters only through its first bit. The stimulus drives each sorted pattern through the inverse of the default lane order on the falling clock edge. It covers single-tap runs, runs that end at group boundaries, runs one tap short of full length, noisy tails, both polarities, both uniform vectors, and raw vectors that contain a bubble before sorting.

// File: rtl/tap_enc_pkg.sv
package tap_enc_pkg;

  localparam int unsigned LANES = 4;

  typedef int unsigned lane_order_t [LANES];

  // True when every lane index 0..LANES-1 appears exactly once.
  function automatic bit is_lane_perm(lane_order_t ord);
    logic [LANES-1:0] seen;
    seen = '0;
    for (int j = 0; j < LANES; j++) begin
      if (ord[j] >= LANES) return 1'b0;
      if (seen[ord[j][1:0]]) return 1'b0;
      seen[ord[j][1:0]] = 1'b1;
    end
    return 1'b1;
  endfunction

endpackage

// File: rtl/tap_reorder.sv
module tap_reorder #(
  parameter int unsigned              NUM_CARRY  = 8,
  parameter tap_enc_pkg::lane_order_t LANE_ORDER = '{0, 2, 1, 3},
  localparam int unsigned             NUM_TAPS   = tap_enc_pkg::LANES * NUM_CARRY
) (
  input  logic [NUM_TAPS-1:0] raw,
  output logic [NUM_TAPS-1:0] sorted
);

  for (genvar c = 0; c < NUM_CARRY; c++) begin : g_carry
    for (genvar j = 0; j < tap_enc_pkg::LANES; j++) begin : g_lane
      assign sorted[tap_enc_pkg::LANES*c + j] = raw[tap_enc_pkg::LANES*c + LANE_ORDER[j]];
    end
  end

endmodule

// File: rtl/chunk_scan.sv
module chunk_scan #(
  parameter int unsigned  CHUNK = 8,
  localparam int unsigned LW    = $clog2(CHUNK)
) (
  input  logic [CHUNK-1:0] bits,
  input  logic             ref_bit,
  output logic             all_match,
  output logic [LW-1:0]    lead
);

  always_comb begin
    logic run;
    run  = 1'b1;
    lead = '0;
    for (int b = 0; b < CHUNK; b++) begin
      if (run && (bits[b] == ref_bit)) lead = lead + LW'(1);
      else                             run  = 1'b0;
    end
    all_match = run;
  end

endmodule

// File: rtl/run_merge.sv
module run_merge #(
  parameter int unsigned NUM_CHUNKS = 4,
  parameter int unsigned CHUNK      = 8,
  parameter int unsigned CNT_W      = 5,
  localparam int unsigned LW        = $clog2(CHUNK)
) (
  input  logic [NUM_CHUNKS-1:0]    all_match,
  input  logic [NUM_CHUNKS*LW-1:0] lead,
  output logic                     found,
  output logic [CNT_W-1:0]         count
);

  // The first group that breaks the run decides the count.
  always_comb begin
    found = 1'b0;
    count = '0;
    for (int k = 0; k < NUM_CHUNKS; k++) begin
      if (!found && !all_match[k]) begin
        found = 1'b1;
        count = CNT_W'(k * CHUNK) + CNT_W'(lead[k*LW +: LW]);
      end
    end
  end

endmodule

// File: rtl/tap_encoder.sv
module tap_encoder #(
  parameter int unsigned              NUM_CARRY     = 8,
  parameter int unsigned              GROUP_CARRIES = 2,
  parameter tap_enc_pkg::lane_order_t LANE_ORDER    = '{0, 2, 1, 3},
  localparam int unsigned             NUM_TAPS      = tap_enc_pkg::LANES * NUM_CARRY,
  localparam int unsigned             CNT_W         = $clog2(NUM_TAPS)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_TAPS-1:0] tap_raw,
  output logic                out_valid,
  output logic                out_rising,
  output logic [CNT_W-1:0]    out_count
);

  localparam int unsigned CHUNK      = tap_enc_pkg::LANES * GROUP_CARRIES;
  localparam int unsigned NUM_CHUNKS = NUM_CARRY / GROUP_CARRIES;
  localparam int unsigned LW         = $clog2(CHUNK);

  if (!tap_enc_pkg::is_lane_perm(LANE_ORDER)) begin : g_bad_order
    $error("tap_encoder: LANE_ORDER is not a permutation of 0..3");
  end
  if ((NUM_CARRY % GROUP_CARRIES) != 0) begin : g_bad_group
    $error("tap_encoder: NUM_CARRY must be a multiple of GROUP_CARRIES");
  end

  logic [NUM_TAPS-1:0] sorted;

  tap_reorder #(
    .NUM_CARRY (NUM_CARRY),
    .LANE_ORDER(LANE_ORDER)
  ) u_reorder (
    .raw   (tap_raw),
    .sorted(sorted)
  );

  // Stage one: per-group scan against the polarity bit.
  logic [NUM_CHUNKS-1:0]    grp_all;
  logic [NUM_CHUNKS*LW-1:0] grp_lead;

  for (genvar k = 0; k < NUM_CHUNKS; k++) begin : g_scan
    chunk_scan #(.CHUNK(CHUNK)) u_scan (
      .bits     (sorted[k*CHUNK +: CHUNK]),
      .ref_bit  (sorted[0]),
      .all_match(grp_all[k]),
      .lead     (grp_lead[k*LW +: LW])
    );
  end

  logic                     s1_ref;
  logic [NUM_CHUNKS-1:0]    s1_all;
  logic [NUM_CHUNKS*LW-1:0] s1_lead;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_ref  <= 1'b0;
      s1_all  <= '1;
      s1_lead <= '0;
    end else begin
      s1_ref  <= sorted[0];
      s1_all  <= grp_all;
      s1_lead <= grp_lead;
    end
  end

  // Stage two: merge group results into the final count.
  logic             m_found;
  logic [CNT_W-1:0] m_count;

  run_merge #(
    .NUM_CHUNKS(NUM_CHUNKS),
    .CHUNK     (CHUNK),
    .CNT_W     (CNT_W)
  ) u_merge (
    .all_match(s1_all),
    .lead     (s1_lead),
    .found    (m_found),
    .count    (m_count)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      out_rising <= 1'b0;
      out_count  <= '0;
    end else begin
      out_valid  <= m_found;
      out_rising <= m_found & s1_ref;
      out_count  <= m_found ? m_count : '0;
    end
  end

endmodule

// File: rtl/tap_encoder_checker.sv
module tap_encoder_checker #(
  parameter int unsigned NUM_TAPS   = 32,
  parameter int unsigned CNT_W      = 5,
  parameter int unsigned FIRST_LANE = 0
) (
  input logic                clk,
  input logic                rst,
  input logic [NUM_TAPS-1:0] tap_raw,
  input logic                out_valid,
  input logic                out_rising,
  input logic [CNT_W-1:0]    out_count
);

  assert_count_range_R7: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_count != '0) && (int'(out_count) < int'(NUM_TAPS)));

  assert_idle_zero_R4: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> (out_count == '0) && !out_rising);

  assert_uniform_invalid_R4: assert property (@(posedge clk) disable iff (rst)
    ((&tap_raw) || !(|tap_raw)) |=> ##1 !out_valid);

  assert_polarity_R3: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_rising == $past(tap_raw[FIRST_LANE], 2)));

  assert_latency_R5: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (!(&$past(tap_raw, 2)) && (|$past(tap_raw, 2))));

  assert_reset_clear_R6: assert property (@(posedge clk)
    rst |=> !out_valid && (out_count == '0) && !out_rising);

endmodule

bind tap_encoder tap_encoder_checker #(
  .NUM_TAPS  (NUM_TAPS),
  .CNT_W     (CNT_W),
  .FIRST_LANE(LANE_ORDER[0])
) u_chk (.*);

// File: tb/test_tap_encoder.sv
module test_tap_encoder;

  localparam int W  = 32;
  localparam int CW = 5;

  typedef struct packed {
    logic [W-1:0]  sorted;
    logic          v;
    logic          r;
    logic [CW-1:0] cnt;
  } vec_t;

  localparam vec_t TABLE [12] = '{
    '{32'h0000_0001, 1'b1, 1'b1, 5'd1},
    '{32'h0000_00FF, 1'b1, 1'b1, 5'd8},
    '{32'h0000_01FF, 1'b1, 1'b1, 5'd9},
    '{32'h7FFF_FFFF, 1'b1, 1'b1, 5'd31},
    '{32'hFFFF_FFFE, 1'b1, 1'b0, 5'd1},
    '{32'hFFFF_0000, 1'b1, 1'b0, 5'd16},
    '{32'h8000_0000, 1'b1, 1'b0, 5'd31},
    '{32'h0000_00F7, 1'b1, 1'b1, 5'd3},
    '{32'hFFFF_FFFF, 1'b0, 1'b0, 5'd0},
    '{32'h0000_0000, 1'b0, 1'b0, 5'd0},
    '{32'hA5A5_FF0F, 1'b1, 1'b1, 5'd4},
    '{32'h00FF_FFFF, 1'b1, 1'b1, 5'd24}
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [W-1:0]  tap_raw = '0;
  logic          out_valid;
  logic          out_rising;
  logic [CW-1:0] out_count;
  int            checks = 0;
  int            errors = 0;
  bit            done = 1'b0;

  always #5 clk = ~clk;

  tap_encoder i_tap_encoder (
    .clk       (clk),
    .rst       (rst),
    .tap_raw   (tap_raw),
    .out_valid (out_valid),
    .out_rising(out_rising),
    .out_count (out_count)
  );

  // Inverse of the default lane order (0,2,1,3): raw[4c+ord[j]] = sorted[4c+j].
  function automatic logic [W-1:0] to_raw(logic [W-1:0] s);
    int ord [4] = '{0, 2, 1, 3};
    logic [W-1:0] r;
    r = '0;
    for (int c = 0; c < W/4; c++)
      for (int j = 0; j < 4; j++)
        r[4*c + ord[j]] = s[4*c + j];
    return r;
  endfunction

  task automatic check_out(string tag, logic v, logic r, logic [CW-1:0] c);
    checks++;
    if (out_valid !== v) begin
      errors++;
      $display("FAIL %s out_valid actual %b expected %b", tag, out_valid, v);
    end
    checks++;
    if (out_rising !== r) begin
      errors++;
      $display("FAIL %s out_rising actual %b expected %b", tag, out_rising, r);
    end
    checks++;
    if (out_count !== c) begin
      errors++;
      $display("FAIL %s out_count actual %0d expected %0d", tag, out_count, c);
    end
  endtask

  task automatic apply(logic [W-1:0] raw);
    @(negedge clk);
    tap_raw = raw;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check_out("R6 reset state", 1'b0, 1'b0, 5'd0);
    rst = 1'b0;

    // Table walk: sorted patterns sent through the inverse lane order.
    for (int i = 0; i < 12; i++) begin
      apply(to_raw(TABLE[i].sorted));
      check_out(TABLE[i].v ? "R2/R3/R7 table" : "R4 uniform", TABLE[i].v, TABLE[i].r, TABLE[i].cnt);
    end

    // R1: a raw bubble (0101) sorts into a clean run of two.
    apply(32'h0000_0005);
    check_out("R1 raw bubble", 1'b1, 1'b1, 5'd2);
    // R1: raw 0011 sorts to 1..0..1, run of one.
    apply(32'h0000_0003);
    check_out("R1 lane swap", 1'b1, 1'b1, 5'd1);

    // R5: back-to-back vectors, one result per cycle, two edges late.
    @(negedge clk); tap_raw = to_raw(32'h0000_003F);
    @(negedge clk); tap_raw = to_raw(32'hFFFF_F000);
    @(negedge clk); tap_raw = 32'h0;
    check_out("R5 stream 0", 1'b1, 1'b1, 5'd6);
    @(negedge clk); tap_raw = to_raw(32'h0000_0007);
    check_out("R5 stream 1", 1'b1, 1'b0, 5'd12);
    @(negedge clk);
    check_out("R5 stream 2", 1'b0, 1'b0, 5'd0);
    @(negedge clk);
    check_out("R5 stream 3", 1'b1, 1'b1, 5'd3);

    // R6: reset during a valid stream clears outputs at the next edge.
    apply(to_raw(32'h0000_0FFF));
    check_out("R6 before reset", 1'b1, 1'b1, 5'd12);
    rst = 1'b1;
    @(negedge clk);
    check_out("R6 reset midstream", 1'b0, 1'b0, 5'd0);
    rst = 1'b0;
    apply(to_raw(32'h0000_0FFF));
    check_out("R6 after release", 1'b1, 1'b1, 5'd12);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule